// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 64 peripheral interrupt lines and holds each one in a sticky pending flag. Every source has its own enable bit and its own 5-bit priority key: a 3-bit level and a 2-bit sub-level. On every cycle the controller picks one pending, enabled source. The winner is the source with the highest level, then the highest sub-level, then the lowest source index.

The winning request goes to the processor core only when its level is strictly above the core's current level (`core_ipl`). It carries a vector number and the level. In multi-vector mode the vector is the source index. In single-vector mode every request uses vector 0.

Software reaches every register over a simple 32-bit word bus. Each register sits in a 16-byte slot. The slot holds the register itself and three write-only aliases that clear, set or toggle the bits written as 1, so an update needs no read-modify-write. An interrupt handler turns off the source's enable bit and clears its flag before it lowers `core_ipl`. If it lowers the level first, the same request fires again.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After synchronous reset every register reads as 0 and `irq_req`, `irq_vector` and `irq_level` are 0.
- R2: In every register slot, a write at slot offset 0x0 loads the register. Writes at offsets 0x4, 0x8 and 0xC clear, set and invert, respectively, each register bit whose write-data bit is 1.
- R3: The register map is as follows:
  - Mode register: offset 0x00, bit 0 selects multi-vector mode.
  - Pending-flag registers: 0x30 + 16·n.
  - Enable registers: 0x60 + 16·n.
  - In flag and enable register n, bit k belongs to source 32·n + k.
  - Priority registers: 0x90 + 16·r, one per group of four sources. Source s uses register s/4 with its field at bit 8·(s mod 4). Field bits 1:0 hold the sub-level and bits 4:2 hold the level.
- R4: While a source input is 1 at a clock edge, that source's flag becomes 1. The flag stays 1 until software clears it. A pulse wins over a software clear of the same bit in the same cycle.
- R5: A source takes part in arbitration only if its flag is 1, its enable is 1 and its level is nonzero.
- R6: Among the sources that take part, the winner has the highest level. Ties go to the highest sub-level, then to the lowest source index.
- R7: `irq_req` is 1 only when the winner's level is strictly greater than `core_ipl`. Otherwise `irq_req`, `irq_vector` and `irq_level` are all 0. The outputs are registered and reflect register or input state one clock later.
- R8: When a request is raised, `irq_level` is the winner's level. `irq_vector` is the winner's index when mode bit 0 is 1, and 0 when mode bit 0 is 0.
- R9: The following read as 0, and writes to them have no effect:
  - reserved bits: priority bits 7:5 of each byte, and mode bits 31:1
  - alias offsets on read
  - unmapped or non-word-aligned addresses

  Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | NUM_SRC | Peripheral interrupt lines; a 1 sets the matching flag |
| core_ipl | input | 3 | Core's current priority level |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Request to the core |
| irq_vector | output | VEC_W | Vector number of the request |
| irq_level | output | 3 | Priority level of the request |

## Verification
The case that needs the most care is a peripheral pulse and a software clear of the same flag bit landing on one clock edge. The bench provokes it by driving a clear-alias write and the source line in the same cycle, while the write also clears a second flag that has no pulse. It then reads the flag register back and expects the pulsed bit still set and the other bit cleared. A second collision arises when arbitration sees a new flag or priority write in the same edge as a change of `core_ipl`. The bench judges this by checking the registered request exactly one cycle after each change.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BANK_W = 32;

  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_CLR  = 2'd1,
    OP_SET  = 2'd2,
    OP_INV  = 2'd3
  } alias_op_e;

  // 16-byte slot numbers (address >> 4)
  localparam int SLOT_MODE = 0;
  localparam int SLOT_FLAG = 3;
  localparam int SLOT_EN   = 6;
  localparam int SLOT_PRI  = 9;

  localparam logic [31:0] MODE_MASK = 32'h0000_0001;
  localparam logic [31:0] PRI_MASK  = 32'h1F1F_1F1F;
  localparam logic [31:0] FULL_MASK = 32'hFFFF_FFFF;
endpackage

// File: rtl/vic_alias_reg.sv
module vic_alias_reg
  import vic_pkg::*;
#(
  parameter logic [31:0] MASK = FULL_MASK
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  alias_op_e   op,
  input  logic [31:0] wdata,
  input  logic [31:0] hw_set,
  output logic [31:0] q
);
  logic [31:0] sw_nxt;

  always_comb begin
    sw_nxt = q;
    if (we) begin
      case (op)
        OP_BASE: sw_nxt = wdata;
        OP_CLR:  sw_nxt = q & ~wdata;
        OP_SET:  sw_nxt = q | wdata;
        OP_INV:  sw_nxt = q ^ wdata;
        default: sw_nxt = q;
      endcase
    end
  end

  // hardware set is applied after the software update, so it wins
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (sw_nxt | hw_set) & MASK;
  end

  p_base_write_r2: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_BASE && hw_set == '0) |=> (q == ($past(wdata) & MASK)));

  p_clear_alias_r2: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_CLR && hw_set == '0) |=> ((q & $past(wdata)) == '0));

  p_set_alias_r2: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_SET) |=> ((q & $past(wdata & MASK)) == $past(wdata & MASK)));

  p_pulse_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((q & $past(hw_set & MASK)) == $past(hw_set & MASK)));
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NUM_SRC = 64,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    cand,
  input  logic [NUM_SRC-1:0][4:0] key,
  input  logic [2:0]            core_ipl,
  input  logic                  mvec,
  output logic                  irq_req,
  output logic [VEC_W-1:0]      irq_vector,
  output logic [2:0]            irq_level
);
  logic             found;
  logic [4:0]       best_key;
  logic [VEC_W-1:0] best_idx;
  logic             req_d;

  // strict compare keeps the lowest index on a full tie
  always_comb begin
    found    = 1'b0;
    best_key = '0;
    best_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && key[i][4:2] != 3'd0 && (!found || key[i] > best_key)) begin
        found    = 1'b1;
        best_key = key[i];
        best_idx = VEC_W'(i);
      end
    end
    req_d = found && (best_key[4:2] > core_ipl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req    <= 1'b0;
      irq_vector <= '0;
      irq_level  <= '0;
    end else begin
      irq_req    <= req_d;
      irq_level  <= req_d ? best_key[4:2] : 3'd0;
      irq_vector <= (req_d && mvec) ? best_idx : '0;
    end
  end

  p_req_above_ipl_r7: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_level > $past(core_ipl)));

  p_level_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_level != 3'd0));

  p_single_vec_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !$past(mvec)) |-> (irq_vector == '0));

  p_winner_has_cand_r5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(cand != '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 9,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic [2:0]         core_ipl,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vector,
  output logic [2:0]         irq_level
);
  localparam int NBANK  = NUM_SRC / BANK_W;
  localparam int NPRI   = NUM_SRC / 4;
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  alias_op_e         op;
  logic              aligned;

  assign slot    = bus_addr[ADDR_W-1:4];
  assign op      = alias_op_e'(bus_addr[3:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);

  logic [31:0]       mode_q;
  logic [NBANK-1:0][31:0] flag_q;
  logic [NBANK-1:0][31:0] en_q;
  logic [NPRI-1:0][31:0]  pri_q;

  vic_alias_reg #(.MASK(MODE_MASK)) u_mode (
    .clk(clk), .rst(rst),
    .we(bus_we && aligned && slot == SLOT_W'(SLOT_MODE)),
    .op(op), .wdata(bus_wdata), .hw_set(32'h0), .q(mode_q)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    vic_alias_reg #(.MASK(FULL_MASK)) u_flag (
      .clk(clk), .rst(rst),
      .we(bus_we && aligned && slot == SLOT_W'(SLOT_FLAG + b)),
      .op(op), .wdata(bus_wdata),
      .hw_set(src_pulse[b*BANK_W +: BANK_W]), .q(flag_q[b])
    );
    vic_alias_reg #(.MASK(FULL_MASK)) u_en (
      .clk(clk), .rst(rst),
      .we(bus_we && aligned && slot == SLOT_W'(SLOT_EN + b)),
      .op(op), .wdata(bus_wdata), .hw_set(32'h0), .q(en_q[b])
    );
  end

  for (genvar r = 0; r < NPRI; r++) begin : g_pri
    vic_alias_reg #(.MASK(PRI_MASK)) u_pri (
      .clk(clk), .rst(rst),
      .we(bus_we && aligned && slot == SLOT_W'(SLOT_PRI + r)),
      .op(op), .wdata(bus_wdata), .hw_set(32'h0), .q(pri_q[r])
    );
  end

  // per-source candidate bit and priority key
  logic [NUM_SRC-1:0]      cand;
  logic [NUM_SRC-1:0][4:0] key;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign cand[s] = flag_q[s / BANK_W][s % BANK_W] & en_q[s / BANK_W][s % BANK_W];
    assign key[s]  = pri_q[s / 4][8*(s % 4) +: 5];
  end

  vic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst(rst),
    .cand(cand), .key(key),
    .core_ipl(core_ipl), .mvec(mode_q[0]),
    .irq_req(irq_req), .irq_vector(irq_vector), .irq_level(irq_level)
  );

  // read path: only the base offset of a mapped slot returns data
  logic [31:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (aligned && op == OP_BASE) begin
      if (slot == SLOT_W'(SLOT_MODE)) rd_d = mode_q;
      for (int b = 0; b < NBANK; b++) begin
        if (slot == SLOT_W'(SLOT_FLAG + b)) rd_d = flag_q[b];
        if (slot == SLOT_W'(SLOT_EN + b))   rd_d = en_q[b];
      end
      for (int r = 0; r < NPRI; r++) begin
        if (slot == SLOT_W'(SLOT_PRI + r)) rd_d = pri_q[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  p_alias_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BASE) |=> (bus_rdata == '0));

  p_no_req_without_cand_r5: assert property (@(posedge clk) disable iff (rst)
    (cand == '0) |=> !irq_req);
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int NUM_SRC = 64;
  localparam int ADDR_W  = 9;
  localparam int VEC_W   = 6;

  logic               clk = 1'b0;
  logic               rst;
  logic [NUM_SRC-1:0] src_pulse;
  logic [2:0]         core_ipl;
  logic [ADDR_W-1:0]  bus_addr;
  logic               bus_we;
  logic [31:0]        bus_wdata;
  logic [31:0]        bus_rdata;
  logic               irq_req;
  logic [VEC_W-1:0]   irq_vector;
  logic [2:0]         irq_level;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_vec_irq_ctrl (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .core_ipl(core_ipl),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_vector(irq_vector),
    .irq_level(irq_level)
  );

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_pulse = '0; core_ipl = 3'd0;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = ADDR_W'(addr); bus_wdata = data; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input int addr, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = ADDR_W'(addr);
    @(negedge clk);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read 0x%0h got 0x%08h expected 0x%08h", req, addr, bus_rdata, exp);
    end
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] bits);
    @(negedge clk);
    src_pulse = bits;
    @(negedge clk);
    src_pulse = '0;
  endtask

  // waits for the registered outputs, then compares them
  task automatic irq_check(input logic req, input int vec, input int lvl, input string tag);
    @(negedge clk);
    checks++;
    if (irq_req !== req || irq_vector !== VEC_W'(vec) || irq_level !== 3'(lvl)) begin
      errors++;
      $display("FAIL %s: req/vec/lvl got %0b/%0d/%0d expected %0b/%0d/%0d",
               tag, irq_req, irq_vector, irq_level, req, vec, lvl);
    end
  endtask

  function automatic int pri_addr(input int src, input int op);
    return 'h90 + 16 * (src / 4) + 4 * op;
  endfunction

  function automatic logic [31:0] pri_data(input int src, input int lvl, input int sub);
    return 32'((lvl * 4 + sub)) << (8 * (src % 4));
  endfunction

  task automatic t_reset();
    do_reset();
    irq_check(1'b0, 0, 0, "R1 outputs after reset");
    rd_check('h00, 32'h0, "R1 mode register");
    rd_check('h30, 32'h0, "R1 flag register");
    rd_check('h90, 32'h0, "R1 priority register");
  endtask

  task automatic t_alias();
    do_reset();
    wr('h60, 32'h1234_5678);
    rd_check('h60, 32'h1234_5678, "R2 base load");
    wr('h68, 32'h8000_0000);
    wr('h64, 32'h0000_0078);
    rd_check('h60, 32'h9234_5600, "R2 set and clear aliases");
    wr('h6C, 32'h0000_FFFF);
    rd_check('h60, 32'h9234_A9FF, "R2 invert alias");
    wr('h40, 32'h0000_00A5);
    rd_check('h40, 32'h0000_00A5, "R3 second flag bank offset");
  endtask

  task automatic t_reserved();
    do_reset();
    wr('h90, 32'hFFFF_FFFF);
    rd_check('h90, 32'h1F1F_1F1F, "R9 reserved priority bits");
    rd_check('h98, 32'h0, "R9 alias reads zero");
    wr('h20, 32'hFFFF_FFFF);
    rd_check('h20, 32'h0, "R9 unmapped slot");
    wr('h61, 32'hFFFF_FFFF);
    rd_check('h60, 32'h0, "R9 misaligned write ignored");
    wr('h00, 32'hFFFF_FFFF);
    rd_check('h00, 32'h1, "R9 reserved mode bits");
  endtask

  task automatic t_sticky_enable();
    do_reset();
    wr('h08, 32'h1);
    wr(pri_addr(5, 2), pri_data(5, 3, 0));
    pulse(64'h20);
    irq_check(1'b0, 0, 0, "R5 flag without enable");
    rd_check('h30, 32'h20, "R4 pulse sets flag");
    wr('h68, 32'h20);
    irq_check(1'b1, 5, 3, "R5 enabled source requests");
    rd_check('h30, 32'h20, "R4 flag stays set");
    // level 0 source never requests
    wr('h34, 32'h20);
    wr('h68, 32'h200);
    pulse(64'h200);
    irq_check(1'b0, 0, 0, "R5 level zero is disabled");
  endtask

  task automatic t_arbitration();
    do_reset();
    wr('h08, 32'h1);
    wr('h68, 32'h0000_0408);
    wr('h78, 32'h0000_0100);
    wr(pri_addr(3, 2), pri_data(3, 4, 0));
    wr(pri_addr(10, 2), pri_data(10, 5, 1));
    wr(pri_addr(40, 2), pri_data(40, 5, 1));
    pulse((64'h1 << 3) | (64'h1 << 10) | (64'h1 << 40));
    irq_check(1'b1, 10, 5, "R6 full tie picks lowest index");
    wr(pri_addr(40, 2), pri_data(40, 0, 3));
    irq_check(1'b1, 40, 5, "R6 sub-level breaks tie");
    wr('h44, 32'h0000_0100);
    irq_check(1'b1, 10, 5, "R6 falls back after clear");
    wr('h34, 32'h0000_0400);
    irq_check(1'b1, 3, 4, "R6 lower level wins when alone");
  endtask

  task automatic t_ipl();
    do_reset();
    wr('h08, 32'h1);
    wr('h68, 32'h0010_0000);
    wr(pri_addr(20, 2), pri_data(20, 5, 0));
    pulse(64'h1 << 20);
    @(negedge clk);
    core_ipl = 3'd5;
    irq_check(1'b0, 0, 0, "R7 equal level is blocked");
    core_ipl = 3'd4;
    irq_check(1'b1, 20, 5, "R7 level above ipl requests");
    // handler order: disable, acknowledge, then lower the level
    wr('h64, 32'h0010_0000);
    wr('h34, 32'h0010_0000);
    core_ipl = 3'd0;
    irq_check(1'b0, 0, 0, "R7 no re-entry after handler");
  endtask

  task automatic t_single_vec();
    do_reset();
    wr('h68, 32'h0000_0080);
    wr(pri_addr(7, 2), pri_data(7, 6, 2));
    pulse(64'h80);
    irq_check(1'b1, 0, 6, "R8 single-vector mode uses vector 0");
    wr('h08, 32'h1);
    irq_check(1'b1, 7, 6, "R8 multi-vector mode uses index");
  endtask

  task automatic t_collision();
    do_reset();
    pulse(64'h40);
    // clear of bits 6 and 7 lands with a pulse on 7
    @(negedge clk);
    bus_addr = ADDR_W'('h34); bus_wdata = 32'hC0; bus_we = 1'b1;
    src_pulse = 64'h80;
    @(negedge clk);
    bus_we = 1'b0; src_pulse = '0;
    rd_check('h30, 32'h80, "R4 pulse wins over same-cycle clear");
  endtask

  initial begin
    rst = 1'b1; src_pulse = '0; core_ipl = '0;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    t_reset();
    t_alias();
    t_reserved();
    t_sticky_enable();
    t_arbitration();
    t_ipl();
    t_single_vec();
    t_collision();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule